// File: doc/BRIEF.md
# Two-Phase Set-Associative Read Cache

This block is a read-only, set-associative cache that splits every lookup into two serial phases to keep the data arrays quiet. In the first phase, which is one cycle long, only the tag arrays of the addressed set are read, in all ways, and compared against the request. In the second phase, one cycle later, exactly one data way is read: the way whose tag matched. A miss never touches a data way. Instead it starts a line refill from the memory side, writes the refilled line into the least-recently-used way, and answers with the requested word.

The processor side is a valid/ready request channel that carries a byte address and a valid/ready response channel that returns one 32-bit word. The cache accepts a request only while it is idle. Once `rsp_valid` rises, it holds the response word steady until `rsp_ready` is seen. The memory side has the same two kinds of channel. `mem_req_valid` stays high with a steady line-aligned address until `mem_req_ready` is seen. The refill words are then taken one per `mem_rsp_valid`/`mem_rsp_ready` beat, in ascending address order, and the memory may leave gaps between beats.

Two one-hot strobe buses report array activity. `tag_en` marks the tag ways that are read in a cycle. `data_en` marks the data way that is read in a cycle. Refill writes do not appear on `data_en`. A bench can count these strobes to measure the activation cost of each access.

Top module: `phased_cache`

## Requirements
- R1: After reset, `req_ready` is 1, while `rsp_valid`, `mem_req_valid`, `tag_en` and `data_en` are 0. Every line is invalid, so the first access to any address is a miss.
- R2: The cycle after a request is accepted is the tag phase. In that cycle `tag_en` has all WAYS bits set and `data_en` is 0. `tag_en` is either all ones or all zeros, and it is never high in two consecutive cycles.
- R3: On a tag hit, the cycle after the tag phase sets exactly one bit of `data_en`: the bit of the matching way. The next cycle raises `rsp_valid`, so the response is visible 3 falling clock edges after the accepting rising edge. The returned word is the one at word offset `addr[4:2]` of the line.
- R4: On a tag miss, `data_en` stays 0 for the whole access. A single memory request is issued, and its address is the request address with the 5 offset bits cleared.
- R5: A refill takes LINE_WORDS beats, where beat k carries the word at line base + 4k. The response is the word at offset `addr[4:2]`. After the refill, the line hits.
- R6: Replacement evicts the way with the oldest age in the set. Ages start equal to the way index, so the first fills of a set go to ways 3, 2, 1 and then 0. Every hit and every fill makes the touched way the youngest.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `req_ready`=0 all hold. While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` both hold.
- R8: A hit activates WAYS tag ways and one data way in total. A miss activates WAYS tag ways and no data way.
- R9: The sets are independent. Fills in one set never evict or disturb a line held in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache can accept a request (idle) |
| req_addr | input | ADDR_W | Byte address of the requested word |
| rsp_valid | output | 1 | Response word valid |
| rsp_ready | input | 1 | Processor accepts the response |
| rsp_data | output | DATA_W | Requested word |
| mem_req_valid | output | 1 | Line refill request valid |
| mem_req_ready | input | 1 | Memory accepts the refill request |
| mem_req_addr | output | ADDR_W | Line-aligned refill address |
| mem_rsp_valid | input | 1 | Refill beat valid |
| mem_rsp_ready | output | 1 | Cache accepts a refill beat |
| mem_rsp_data | input | DATA_W | Refill word, ascending order |
| tag_en | output | WAYS | Per-way tag array read strobe |
| data_en | output | WAYS | Per-way data array read strobe |

## Verification
The bench builds the cache with SETS=4 and keeps WAYS=4 and LINE_WORDS=8. With only 4 sets, a short run of addresses is enough to fill a whole set, force an LRU eviction and then show that an access to a second set is left untouched. The memory model holds off the request handshake on alternate cycles and leaves a gap in every third refill beat, which exercises the hold rules on the memory side. Counting the strobes on each access gives the tag and data activation totals for hits and for misses.

// File: rtl/phc_pkg.sv
package phc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_READ,
    ST_MREQ,
    ST_FILL,
    ST_RESP
  } phc_state_e;
endpackage

// File: rtl/phc_tag_store.sv
module phc_tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]  way_act,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld;
    logic [TAG_W-1:0] tg [SETS];
    logic             wr_here;

    assign wr_here = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vld <= '0;
      else if (wr_here) vld[wr_set] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_here) tg[wr_set] <= wr_tag;
    end

    assign way_act[w] = rd_en;
    assign hit_vec[w] = rd_en && vld[rd_set] && (tg[rd_set] == rd_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/phc_data_store.sv
module phc_data_store #(
  parameter int WAYS       = 4,
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 8,
  parameter int DATA_W     = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WORD_W = $clog2(LINE_WORDS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int DEPTH  = SETS * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data,
  output logic [WAYS-1:0]   way_act,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data
);
  logic [WAYS-1:0][DATA_W-1:0] way_rd;
  logic [WAY_W-1:0]            sel_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic              rd_here;

    assign rd_here    = rd_en && (rd_way == WAY_W'(w));
    assign way_act[w] = rd_here;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == WAY_W'(w))) mem[{wr_set, wr_word}] <= wr_data;
      if (rd_here) rd_q <= mem[{rd_set, rd_word}];
    end

    assign way_rd[w] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (rd_en) sel_q <= rd_way;
  end

  assign rd_data = way_rd[sel_q];
endmodule

// File: rtl/phc_lru.sv
module phc_lru #(
  parameter int WAYS = 4,
  parameter int SETS = 128,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] q_set,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] age [SETS][WAYS];
  logic [WAY_W-1:0] touched_age;

  assign touched_age = age[touch_set][touch_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)              age[touch_set][w] <= '0;
        else if (age[touch_set][w] < touched_age) age[touch_set][w] <= age[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age[q_set][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
    end
  end
endmodule

// File: rtl/phased_cache.sv
module phased_cache #(
  parameter int WAYS       = 4,
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 8,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [WAYS-1:0]   tag_en,
  output logic [WAYS-1:0]   data_en
);
  import phc_pkg::*;

  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BYTE_W + WORD_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(LINE_WORDS - 1);

  phc_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [WAY_W-1:0]  way_q;
  logic [WORD_W-1:0] beat_q;
  logic [DATA_W-1:0] fill_q;
  logic              from_fill_q;

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_set;
  logic [WORD_W-1:0] a_word;
  logic              tag_hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  victim;
  logic [DATA_W-1:0] rd_data;
  logic              beat_take;
  logic              fill_done;
  logic              unused_lsb;

  assign a_tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign a_set  = addr_q[OFF_W +: IDX_W];
  assign a_word = addr_q[BYTE_W +: WORD_W];
  assign unused_lsb = ^{addr_q[BYTE_W-1:0], req_addr[BYTE_W-1:0]};

  assign beat_take = (state == ST_FILL) && mem_rsp_valid;
  assign fill_done = beat_take && (beat_q == LAST_BEAT);

  phc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_en(state == ST_LOOK), .rd_set(a_set), .rd_tag(a_tag),
    .way_act(tag_en), .hit(tag_hit), .hit_way(hit_way),
    .wr_en(fill_done), .wr_set(a_set), .wr_way(way_q), .wr_tag(a_tag)
  );

  phc_data_store #(.WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk),
    .rd_en(state == ST_READ), .rd_set(a_set), .rd_way(way_q), .rd_word(a_word),
    .rd_data(rd_data), .way_act(data_en),
    .wr_en(beat_take), .wr_set(a_set), .wr_way(way_q), .wr_word(beat_q),
    .wr_data(mem_rsp_data)
  );

  phc_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en((state == ST_READ) || fill_done), .touch_set(a_set), .touch_way(way_q),
    .q_set(a_set), .victim(victim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      addr_q      <= '0;
      way_q       <= '0;
      beat_q      <= '0;
      fill_q      <= '0;
      from_fill_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          state  <= ST_LOOK;
        end
        ST_LOOK: begin
          if (tag_hit) begin
            way_q <= hit_way;
            state <= ST_READ;
          end else begin
            way_q <= victim;
            state <= ST_MREQ;
          end
        end
        ST_READ: begin
          from_fill_q <= 1'b0;
          state       <= ST_RESP;
        end
        ST_MREQ: if (mem_req_ready) begin
          beat_q <= '0;
          state  <= ST_FILL;
        end
        ST_FILL: if (mem_rsp_valid) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == a_word) fill_q <= mem_rsp_data;
          if (beat_q == LAST_BEAT) begin
            from_fill_q <= 1'b1;
            state       <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_RESP);
  assign rsp_data      = from_fill_q ? fill_q : rd_data;
  assign mem_req_valid = (state == ST_MREQ);
  assign mem_req_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_rsp_ready = (state == ST_FILL);
endmodule

// File: rtl/phc_checks.sv
module phc_checks #(
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 8,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  localparam int OFF_W = $clog2(DATA_W / 8) + $clog2(LINE_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [WAYS-1:0]   tag_en,
  input logic [WAYS-1:0]   data_en
);
  // R2
  tag_all_or_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_en == '0) || (&tag_en));
  // R2
  tag_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tag_en) |=> (tag_en == '0));
  // R8
  tag_data_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tag_en) |-> (data_en == '0));
  // R3
  data_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_en));
  // R3
  data_then_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|data_en) |=> rsp_valid);
  // R4
  mreq_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));
  // R4
  mreq_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (data_en == '0));
  // R7
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R7
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind phased_cache phc_checks #(
  .WAYS(WAYS), .LINE_WORDS(LINE_WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_phc_checks (.*);

// File: tb/test_phased_cache.sv
`timescale 1ns/100ps
module test_phased_cache;
  localparam int WAYS = 4, SETS = 4, LW = 8, AW = 32, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, mem_req_valid, mem_rsp_ready;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data, mem_rsp_data = '0;
  logic [AW-1:0] mem_req_addr;
  logic [WAYS-1:0] tag_en, data_en;

  int n_chk = 0, n_err = 0;
  int tag_cnt = 0, data_cnt = 0, mreq_cnt = 0, last_dway = -1;
  logic [AW-1:0] last_maddr = '0;

  always #2.5 clk = ~clk;

  phased_cache #(.WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LW), .ADDR_W(AW), .DATA_W(DW)) i_phased_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .tag_en(tag_en), .data_en(data_en)
  );

  function automatic logic [DW-1:0] memword(input logic [AW-1:0] a);
    return (a * 32'h0001_0003) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [AW-1:0] mk(input int tg, input int st, input int wd);
    return AW'((tg << 7) | (st << 5) | (wd << 2));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model and strobe monitor in one falling-edge process.
  initial begin
    bit req_hs = 0, rsp_hs = 0, active = 0;
    int beat = 0, tick = 0;
    logic [AW-1:0] base = '0, pend = '0;
    forever begin
      @(negedge clk);
      tag_cnt  += $countones(tag_en);
      data_cnt += $countones(data_en);
      for (int w = 0; w < WAYS; w++) if (data_en[w]) last_dway = w;
      if (req_hs) begin
        active = 1; beat = 0; base = pend;
        mreq_cnt++; last_maddr = pend;
      end
      if (rsp_hs) begin
        beat++;
        if (beat == LW) active = 0;
      end
      tick++;
      mem_req_ready = tick[0];
      mem_rsp_valid = active && (tick % 3 != 2);
      mem_rsp_data  = memword(base + AW'(4 * beat));
      req_hs = mem_req_valid && mem_req_ready;
      pend   = mem_req_addr;
      rsp_hs = mem_rsp_valid && mem_rsp_ready;
    end
  end

  task automatic do_read(input logic [AW-1:0] a, input bit exp_hit, input int exp_way, input int hold);
    int t0, d0, m0, lat;
    logic [DW-1:0] snap;
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    req_valid = 1; req_addr = a; rsp_ready = (hold == 0);
    t0 = tag_cnt; d0 = data_cnt; m0 = mreq_cnt;
    @(negedge clk); #1;
    req_valid = 0; lat = 1;
    while (!rsp_valid) begin @(negedge clk); #1; lat++; end
    if (hold > 0) begin
      snap = rsp_data;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk); #1;
        check(rsp_valid && (rsp_data == snap) && !req_ready, "R7 response hold", rsp_data, snap);
      end
      rsp_ready = 1;
    end
    check(rsp_data == memword(a & ~32'h3), exp_hit ? "R3 hit word" : "R5 refill word",
          rsp_data, memword(a & ~32'h3));
    check((mreq_cnt - m0) == (exp_hit ? 0 : 1), "R6 hit/miss outcome", mreq_cnt - m0, exp_hit ? 0 : 1);
    check((tag_cnt - t0) == WAYS, "R8 tag activations", tag_cnt - t0, WAYS);
    check((data_cnt - d0) == (exp_hit ? 1 : 0), exp_hit ? "R8 hit data activations" : "R4 miss data activations",
          data_cnt - d0, exp_hit ? 1 : 0);
    if (exp_hit) begin
      check(lat == 3, "R3 hit latency", lat, 3);
      check(last_dway == exp_way, "R6 hit way", last_dway, exp_way);
    end else begin
      check(last_maddr == (a & ~32'h1F), "R4 refill address", last_maddr, a & ~32'h1F);
    end
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
    check(tag_en == '0, "R1 tag_en", tag_en, 0);
    check(data_en == '0, "R1 data_en", data_en, 0);
  endtask

  task automatic t_cold_and_hit;
    do_read(mk(1, 0, 2), 0, 0, 0);   // R1 cold miss, fills way 3
    do_read(mk(1, 0, 5), 1, 3, 0);   // R5 line now hits, other word
  endtask

  task automatic t_fill_set;
    do_read(mk(2, 0, 0), 0, 0, 0);   // way 2
    do_read(mk(3, 0, 7), 0, 0, 0);   // way 1
    do_read(mk(4, 0, 1), 0, 0, 0);   // way 0
    do_read(mk(1, 1, 3), 0, 0, 0);   // R9 other set, way 3
  endtask

  task automatic t_lru_evict;
    do_read(mk(1, 0, 0), 1, 3, 0);   // R6 touch oldest line
    do_read(mk(5, 0, 4), 0, 0, 0);   // evicts tag 2 (way 2)
    do_read(mk(5, 0, 6), 1, 2, 0);   // R6 new line in way 2
    do_read(mk(2, 0, 0), 0, 0, 0);   // R6 evicted line misses, takes way 1
    do_read(mk(4, 0, 1), 1, 0, 0);   // surviving line
  endtask

  task automatic t_other_set_and_hold;
    do_read(mk(1, 1, 7), 1, 3, 3);   // R9 set 1 undisturbed, R7 hold on hit
    do_read(mk(3, 0, 2), 0, 0, 2);   // R7 hold on a miss response
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cold_and_hit();
    t_fill_set();
    t_lru_evict();
    t_other_set_and_hold();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule